// File: doc/BRIEF.md
# Two-Source Interrupt Controller for a 4-bit Core

This block arbitrates interrupts for a small 4-bit processor core. There are two sources: a timer overflow and a falling edge on an input port. Each source has a request flag and an enable flag. The flags sit in two 4-bit system registers that the core reads and writes over a simple register port with a 1-bit address. Hardware events set the request flags. Software sets or clears the enables, and clears a request by writing 0 to its bit.

A source becomes active when both its request and its enable are 1. The controller does not take an active source at once. It counts instruction-complete strobes: it takes the interrupt only after the instruction that made the pair active and two further instructions have completed. If the pair stops being active at any point in that window, the attempt is abandoned and a new one must start.

On a take, the controller pulses a one-cycle signal that tells the core to push the PC and carry and to branch. It presents the vector of the winning source, with the timer ahead of the port, and clears every enable flag. A wake output tells a halted core that a request is pending.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all enables and requests are 0, both registers read 4'b0000, irq_take_o and wake_o are 0 and irq_vec_o is 0.
- R2: Address 0 holds the enables and address 1 holds the requests. In both registers the timer flag is at bit 2 and the port flag is at bit 0. Bits 3 and 1 read 0 whatever is written. Read data follows reg_addr_i combinationally.
- R3: A tmr_ovf_i or port_fall_i pulse sets the timer or port request. A write to address 1 loads the requests from bits 2 and 0. A hardware set wins over a software write of 0 in the same cycle.
- R4: Instruction N is the instruction whose completion leaves a source active, counting that instruction's own register write. irq_take_o is not raised after N or after I1. It is raised for exactly one cycle, starting at the clock edge where the next instruction after I1 (I2) completes with a source still active.
- R5: If no source is active at any point after N and before I2 completes, including through a write made by I1 or I2, no take occurs. A new N and two more instructions are then needed.
- R6: A request whose enable is 0 never causes a take, however many instructions complete.
- R7: When both sources are active at the take, irq_vec_o is 12'h004 (timer). With only the port active it is 12'h008. irq_vec_o holds the last taken vector until the next take.
- R8: A take clears both enable flags and leaves the request flags unchanged.
- R9: wake_o is 1 whenever either request flag is 1, independent of the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_done_i | input | 1 | One-cycle strobe when the core completes an instruction |
| reg_we_i | input | 1 | System register write strobe |
| reg_addr_i | input | 1 | System register address (0 enables, 1 requests) |
| reg_wdata_i | input | 4 | Write data |
| reg_rdata_o | output | 4 | Read data for reg_addr_i |
| tmr_ovf_i | input | 1 | Timer overflow event pulse |
| port_fall_i | input | 1 | Port falling-edge event pulse |
| irq_take_o | output | 1 | One-cycle pulse: stack PC and carry, branch to irq_vec_o |
| irq_vec_o | output | 12 | Vector of the taken source |
| wake_o | output | 1 | A request is pending |

## Verification
Two pairs of actions can land in the same cycle. The first is a software write of 0 to the request register in the cycle a hardware event sets that request. The bench drives both on one edge and then reads back that the request survived. The second is an instruction completion that also writes a flag. Here I1 or I2 clears an enable or request in the same cycle as its completion strobe, and the bench confirms that irq_take_o stays low. It also confirms that a write which arms a source counts its own instruction as N.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC       = 2;
  localparam int DATA_W     = 4;
  localparam int BIT_STRIDE = 2;   // source i at bit BIT_STRIDE*i
  localparam int SRC_PORT   = 0;
  localparam int SRC_TMR    = 1;   // higher index wins
  localparam logic ADDR_EN  = 1'b0;
  localparam logic ADDR_REQ = 1'b1;

  typedef enum logic [1:0] {
    ACC_IDLE   = 2'd0,
    ACC_SEEN_N = 2'd1,
    ACC_SEEN_1 = 2'd2
  } acc_state_e;
endpackage

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = NSRC,
  parameter int D_W    = DATA_W,
  parameter int STRIDE = BIT_STRIDE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             addr_i,
  input  logic [D_W-1:0]   wdata_i,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic             clr_en_i,
  output logic [N_SRC-1:0] en_o,
  output logic [N_SRC-1:0] req_o,
  output logic [N_SRC-1:0] act_nxt_o,
  output logic [D_W-1:0]   rdata_o
);
  logic [N_SRC-1:0] en_q, req_q, en_nxt, req_nxt;
  logic wr_en, wr_req;

  assign wr_en  = we_i && (addr_i == ADDR_EN);
  assign wr_req = we_i && (addr_i == ADDR_REQ);

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign en_nxt[i]  = wr_en ? wdata_i[STRIDE*i] : en_q[i];
    // hardware set dominates a software clear
    assign req_nxt[i] = hw_set_i[i] | (wr_req ? wdata_i[STRIDE*i] : req_q[i]);
  end

  assign act_nxt_o = en_nxt & req_nxt;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_SRC; i++)
      rdata_o[STRIDE*i] = (addr_i == ADDR_REQ) ? req_q[i] : en_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      req_q <= '0;
    end else begin
      en_q  <= clr_en_i ? '0 : en_nxt;
      req_q <= req_nxt;
    end
  end

  assign en_o  = en_q;
  assign req_o = req_q;
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_ctrl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic instr_done_i,
  input  logic any_act_i,
  output logic take_now_o,
  output logic take_q_o
);
  acc_state_e st_q, st_d;

  assign take_now_o = instr_done_i && any_act_i && (st_q == ACC_SEEN_1);

  always_comb begin
    st_d = st_q;
    if (!any_act_i) st_d = ACC_IDLE;
    else if (instr_done_i) begin
      unique case (st_q)
        ACC_IDLE:   st_d = ACC_SEEN_N;
        ACC_SEEN_N: st_d = ACC_SEEN_1;
        default:    st_d = ACC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ACC_IDLE;
      take_q_o <= 1'b0;
    end else begin
      st_q     <= st_d;
      take_q_o <= take_now_o;
    end
  end
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec #(
  parameter int N_SRC = 2,
  parameter int VEC_W = 12,
  parameter logic [N_SRC*VEC_W-1:0] VEC_PACK = '0
) (
  input  logic [N_SRC-1:0] act_i,
  output logic [VEC_W-1:0] vec_o
);
  // later (higher) index overrides: highest index has priority
  always_comb begin
    vec_o = '0;
    for (int i = 0; i < N_SRC; i++)
      if (act_i[i]) vec_o = VEC_PACK[i*VEC_W +: VEC_W];
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] TMR_VEC = 12'h004,
  parameter logic [VEC_W-1:0] PRT_VEC = 12'h008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_done_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              tmr_ovf_i,
  input  logic              port_fall_i,
  output logic              irq_take_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              wake_o
);
  localparam logic [NSRC*VEC_W-1:0] VEC_PACK = {TMR_VEC, PRT_VEC};

  logic [NSRC-1:0] hw_set, en_q, req_q, act_nxt;
  logic            take_now;
  logic [VEC_W-1:0] vec_sel, vec_q;

  assign hw_set[SRC_TMR]  = tmr_ovf_i;
  assign hw_set[SRC_PORT] = port_fall_i;

  irq_flag_regs #(.N_SRC(NSRC), .D_W(DATA_W), .STRIDE(BIT_STRIDE)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .hw_set_i  (hw_set),
    .clr_en_i  (take_now),
    .en_o      (en_q),
    .req_o     (req_q),
    .act_nxt_o (act_nxt),
    .rdata_o   (reg_rdata_o)
  );

  irq_accept_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .instr_done_i (instr_done_i),
    .any_act_i    (|act_nxt),
    .take_now_o   (take_now),
    .take_q_o     (irq_take_o)
  );

  irq_prio_vec #(.N_SRC(NSRC), .VEC_W(VEC_W), .VEC_PACK(VEC_PACK)) u_prio (
    .act_i (act_nxt),
    .vec_o (vec_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       vec_q <= '0;
    else if (take_now) vec_q <= vec_sel;
  end

  assign irq_vec_o = vec_q;
  assign wake_o    = |req_q;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int VEC_W = 12,
  parameter logic [VEC_W-1:0] TMR_VEC = 12'h004,
  parameter logic [VEC_W-1:0] PRT_VEC = 12'h008
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tmr_ovf_i,
  input logic             port_fall_i,
  input logic             irq_take_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             wake_o,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  req_q
);
  a_r3_tmr_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> req_q[SRC_TMR]);
  a_r3_port_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_fall_i |=> req_q[SRC_PORT]);
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |=> !irq_take_o);
  a_r8_en_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (en_q == '0));
  a_r7_vec_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_take_o |-> (irq_vec_o == TMR_VEC || irq_vec_o == PRT_VEC));
  a_r9_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmr_ovf_i || port_fall_i) |=> wake_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.VEC_W(VEC_W), .TMR_VEC(TMR_VEC), .PRT_VEC(PRT_VEC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tmr_ovf_i   (tmr_ovf_i),
  .port_fall_i (port_fall_i),
  .irq_take_o  (irq_take_o),
  .irq_vec_o   (irq_vec_o),
  .wake_o      (wake_o),
  .en_q        (en_q),
  .req_q       (req_q)
);

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic instr_done_i = 0, reg_we_i = 0, reg_addr_i = 0, tmr_ovf_i = 0, port_fall_i = 0;
  logic [3:0] reg_wdata_i = '0, reg_rdata_o;
  logic irq_take_o, wake_o;
  logic [11:0] irq_vec_o;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_ctrl dut (.*);

  // entry: we addr wdata[3:0] tmr prt done exp_take exp_wake
  localparam int NV = 14;
  localparam logic [10:0] TBL [NV] = '{
    11'b0_0_0000_1_0_0_0_1,  // timer event
    11'b1_0_0100_0_0_1_0_1,  // N: enable timer
    11'b0_0_0000_0_0_1_0_1,  // I1
    11'b0_0_0000_0_0_0_0_1,  // gap
    11'b0_0_0000_0_0_1_1_1,  // I2 -> take
    11'b0_0_0000_0_0_0_0_1,
    11'b1_1_0000_0_0_0_0_0,  // clear requests
    11'b0_0_0000_0_1_0_0_1,  // port event
    11'b1_0_0001_0_0_1_0_1,  // N: enable port
    11'b1_0_0000_0_0_1_0_1,  // I1 clears enable -> cancel
    11'b1_0_0001_0_0_0_0_1,  // re-enable, no completion
    11'b0_0_0000_0_0_1_0_1,  // N
    11'b0_0_0000_0_0_1_0_1,  // I1
    11'b1_1_0000_0_0_1_0_0   // I2 clears request -> no take
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic addr, input logic [3:0] wd,
                      input logic tmr, input logic prt, input logic done);
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd;
    tmr_ovf_i = tmr; port_fall_i = prt; instr_done_i = done;
    @(posedge clk_i);
    #1;
    reg_we_i = 0; tmr_ovf_i = 0; port_fall_i = 0; instr_done_i = 0;
  endtask

  task automatic rd(input logic addr, output logic [3:0] d);
    @(negedge clk_i);
    reg_addr_i = addr;
    #1 d = reg_rdata_o;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] d;
    #(3*CLK_PERIOD) rst_ni = 1'b1;
    // R1 reset state
    rd(1'b0, d); chk(d == 4'h0, "R1 en reg", d, 0);
    rd(1'b1, d); chk(d == 4'h0, "R1 req reg", d, 0);
    chk(!irq_take_o && !wake_o && irq_vec_o == 0, "R1 outputs",
        {irq_take_o, wake_o, irq_vec_o}, 0);

    // R4 R5 R9 vector table
    for (int i = 0; i < NV; i++) begin
      step(TBL[i][10], TBL[i][9], TBL[i][8:5], TBL[i][4], TBL[i][3], TBL[i][2]);
      chk(irq_take_o == TBL[i][1], $sformatf("R4/R5 take row %0d", i), irq_take_o, TBL[i][1]);
      chk(wake_o == TBL[i][0], $sformatf("R9 wake row %0d", i), wake_o, TBL[i][0]);
      if (i == 4) chk(irq_vec_o == 12'h004, "R7 timer vector", irq_vec_o, 12'h004);
    end

    // R2 register map, unused bits
    step(1, 0, 4'hF, 0, 0, 0);
    rd(1'b0, d); chk(d == 4'b0101, "R2 en map", d, 4'b0101);
    step(1, 0, 4'h0, 0, 0, 0);
    step(1, 1, 4'hF, 0, 0, 0);
    rd(1'b1, d); chk(d == 4'b0101, "R2 req map", d, 4'b0101);
    chk(wake_o, "R9 wake sw req", wake_o, 1);
    step(1, 1, 4'h0, 0, 0, 0);
    rd(1'b1, d); chk(d == 4'h0, "R3 sw clear", d, 0);

    // R3 hw set wins over sw write 0
    step(1, 1, 4'h0, 1, 0, 0);
    rd(1'b1, d); chk(d == 4'b0100, "R3 hw beats sw clear", d, 4'b0100);
    step(1, 1, 4'h0, 0, 1, 0);
    rd(1'b1, d); chk(d == 4'b0001, "R3 port set beats clear", d, 4'b0001);

    // R6 request without enable never taken
    step(0, 0, 0, 1, 0, 0);
    for (int k = 0; k < 5; k++) begin
      step(0, 0, 0, 0, 0, 1);
      chk(!irq_take_o, "R6 no take disabled", irq_take_o, 0);
    end

    // R7 priority with both active, R8 clears enables
    step(1, 0, 4'b0101, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk(!irq_take_o, "R4 no take after I1", irq_take_o, 0);
    step(0, 0, 0, 0, 0, 1);
    chk(irq_take_o, "R4 take after I2", irq_take_o, 1);
    chk(irq_vec_o == 12'h004, "R7 timer priority", irq_vec_o, 12'h004);
    rd(1'b0, d); chk(d == 4'h0, "R8 enables cleared", d, 0);
    rd(1'b1, d); chk(d == 4'b0101, "R8 requests kept", d, 4'b0101);
    chk(!irq_take_o, "R4 one-cycle pulse", irq_take_o, 0);

    // R7 port vector
    step(1, 1, 4'b0001, 0, 0, 0);
    step(1, 0, 4'b0001, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1);
    chk(irq_take_o, "R7 port take", irq_take_o, 1);
    chk(irq_vec_o == 12'h008, "R7 port vector", irq_vec_o, 12'h008);
    step(0, 0, 0, 0, 0, 1);
    chk(irq_vec_o == 12'h008 && !irq_take_o, "R7 vector held", irq_vec_o, 12'h008);

    finish_run();
  end
endmodule